// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Occupancy Flags

This block is a 64-entry, 5-bit first-in/first-out buffer. It sits between a producer and a consumer that talk through strobe pulses rather than a clock-enable. Both strobes arrive as slow, level-style signals. The block samples each one through a two-flop synchronizer on the system clock and turns it into rise and fall events.

A write takes two steps. On the rise of the write strobe the word is written into the RAM slot at the write pointer. On the fall of the strobe the write is committed: the pointer moves on and the occupancy count goes up. A read works the same way. The rise of the read strobe withdraws `out_ready`. The fall commits the read, which frees the slot and advances the read pointer.

A committed word that lands in an empty buffer is loaded into the output hold register on the next clock, so it appears on `dout` one cycle after the commit. Two flags report occupancy. `half_full` marks the upper half. `almost_fe` marks either end of the range. A low `mr_n` clears the block, and `oe_n` gates the data outputs.

The write side is a three-state machine, `wr_state_t`:
- `W_RDY` accepts a write: a rise of the write strobe moves it to `W_BUSY` and writes the RAM.
- `W_BUSY` waits for the fall: the fall commits the word and moves it to `W_WAIT`.
- `W_WAIT` re-checks space. If the buffer is full it stays. If there is room and the strobe level is low, it returns to `W_RDY`. If there is room and the strobe level is still high, it writes the RAM and moves to `W_BUSY`.

The read side is the three-state machine `rd_state_t`:
- `R_WAIT` waits for a word. When the count is non-zero it loads the hold register and moves to `R_VALID`.
- `R_VALID` presents the word: a rise of the read strobe moves it to `R_BUSY`.
- `R_BUSY` waits for the fall: the fall commits the read and moves it back to `R_WAIT`.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave the buffer in the order they were committed, and the buffer holds up to 64 words of 5 bits.
- R2: A rise of `shift_in` while `in_ready` is high stores `din` and drops `in_ready`. The following fall commits the word, and `in_ready` returns high only if fewer than 64 words are held.
- R3: With 64 words held, `in_ready` is low. A `shift_in` pulse that starts and ends while `in_ready` is low changes nothing.
- R4: If `shift_in` stays high while the buffer is full, the pending word is stored as soon as a read commit frees a slot. It is committed when `shift_in` falls.
- R5: A rise of `shift_out` while `out_ready` is high drops `out_ready`. The following fall frees the word. `out_ready` rises again only if another word is held, and `dout` then shows that word.
- R6: A `shift_out` pulse while `out_ready` is low changes nothing. Once the buffer empties, `dout` keeps the last word read.
- R7: After a write commit into an empty buffer, `out_ready` is still low on the next clock and high on the clock after that (one cycle of fall-through).
- R8: While `mr_n` is low, `in_ready`, `out_ready`, `dout`, `half_full` and `almost_fe` are all 0. After release the buffer is empty, `in_ready` is 1 and `almost_fe` is 1.
- R9: `half_full` is 1 exactly when 32 or more words are held.
- R10: `almost_fe` is 1 exactly when 56 or more words, or 8 or fewer words, are held.
- R11: While `oe_n` is 1, `dout` is all zeros. While `oe_n` is 0, `dout` shows the hold register.
- R12: A write commit and a read commit in the same clock leave the occupancy count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mr_n | input | 1 | Master reset, active low, asynchronous assert |
| shift_in | input | 1 | Write strobe: the rise stores a word, the fall commits it |
| din | input | 5 | Write data, held stable while `shift_in` is high |
| in_ready | output | 1 | High when a new write strobe will be accepted |
| shift_out | input | 1 | Read strobe: the rise takes the word, the fall frees it |
| out_ready | output | 1 | High when `dout` holds an unread word |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 5 | Output hold register, or zero when disabled |
| half_full | output | 1 | 32 or more words held |
| almost_fe | output | 1 | 56 or more, or 8 or fewer, words held |

## Verification
The bench builds the block with its default parameters: 64 words of 5 bits. With a 64-word buffer every occupancy boundary can be reached with a few hundred strobe pulses. That covers the almost-empty edge at 8/9 words, the half mark at 31/32, the almost-full edge at 55/56 and the completely full state. Being able to reach the full state is what exercises the ignored write pulse and the held-high write that completes after a read. Simultaneous strobes are applied at 31 and at 32 words, so a count that applied only one of the two commits would move `half_full`.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        W_RDY  = 2'd0,
        W_BUSY = 2'd1,
        W_WAIT = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        R_WAIT  = 2'd0,
        R_VALID = 2'd1,
        R_BUSY  = 2'd2
    } rd_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], strobe};
    end

    // sh[1] is the synchronized level, sh[2] is its previous value
    assign level = sh[1];
    assign rise  = sh[1] & ~sh[2];
    assign fall  = ~sh[1] & sh[2];
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
    parameter int DW    = 5,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_wr_ctrl.sv
module sfifo_wr_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic          rise,
    input  logic          fall,
    input  logic [CW-1:0] cnt,
    output logic          ram_we,
    output logic          commit,
    output logic          rdy,
    output logic [AW-1:0] wptr
);
    wr_state_t st, nxt;
    logic      room;

    assign room = (cnt < CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= W_RDY;
            wptr <= '0;
        end else begin
            st <= nxt;
            if (commit)
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        end
    end

    always_comb begin
        nxt    = st;
        ram_we = 1'b0;
        commit = 1'b0;
        unique case (st)
            W_RDY: begin
                if (rise) begin
                    ram_we = 1'b1;
                    nxt    = W_BUSY;
                end
            end
            W_BUSY: begin
                if (fall) begin
                    commit = 1'b1;
                    nxt    = W_WAIT;
                end
            end
            W_WAIT: begin
                if (room) begin
                    if (level) begin
                        ram_we = 1'b1;
                        nxt    = W_BUSY;
                    end else begin
                        nxt = W_RDY;
                    end
                end
            end
            default: nxt = W_RDY;
        endcase
    end

    assign rdy = (st == W_RDY);
endmodule

// File: rtl/sfifo_rd_ctrl.sv
module sfifo_rd_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic [CW-1:0] cnt,
    output logic          load,
    output logic          commit,
    output logic          valid,
    output logic [AW-1:0] rptr
);
    rd_state_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= R_WAIT;
            rptr <= '0;
        end else begin
            st <= nxt;
            if (commit)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end
    end

    always_comb begin
        nxt    = st;
        load   = 1'b0;
        commit = 1'b0;
        unique case (st)
            R_WAIT: begin
                if (cnt != '0) begin
                    load = 1'b1;
                    nxt  = R_VALID;
                end
            end
            R_VALID: begin
                if (rise) nxt = R_BUSY;
            end
            R_BUSY: begin
                if (fall) begin
                    commit = 1'b1;
                    nxt    = R_WAIT;
                end
            end
            default: nxt = R_WAIT;
        endcase
    end

    assign valid = (st == R_VALID);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DW    = 5,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          mr_n,
    input  logic          shift_in,
    input  logic [DW-1:0] din,
    output logic          in_ready,
    input  logic          shift_out,
    output logic          out_ready,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          half_full,
    output logic          almost_fe
);
    localparam int AW       = $clog2(DEPTH);
    localparam int CW       = $clog2(DEPTH + 1);
    localparam int HALF_LVL = DEPTH / 2;
    localparam int AE_LVL   = DEPTH / 8;
    localparam int AF_LVL   = DEPTH - DEPTH / 8;

    // index 0: write strobe, index 1: read strobe
    logic [1:0] strb, lvl, rs, fl;
    assign strb = {shift_out, shift_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        strobe_sync u_sync (
            .clk   (clk),
            .rst_n (mr_n),
            .strobe(strb[g]),
            .level (lvl[g]),
            .rise  (rs[g]),
            .fall  (fl[g])
        );
    end

    logic [CW-1:0] cnt;
    logic [AW-1:0] wptr, rptr;
    logic [DW-1:0] rdata, hold;
    logic          ram_we, wr_commit, rd_commit, load, wr_rdy, rd_valid;

    sfifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk   (clk),
        .rst_n (mr_n),
        .level (lvl[0]),
        .rise  (rs[0]),
        .fall  (fl[0]),
        .cnt   (cnt),
        .ram_we(ram_we),
        .commit(wr_commit),
        .rdy   (wr_rdy),
        .wptr  (wptr)
    );

    sfifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk   (clk),
        .rst_n (mr_n),
        .rise  (rs[1]),
        .fall  (fl[1]),
        .cnt   (cnt),
        .load  (load),
        .commit(rd_commit),
        .valid (rd_valid),
        .rptr  (rptr)
    );

    sfifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(wptr),
        .wdata(din),
        .raddr(rptr),
        .rdata(rdata)
    );

    // single count update per clock covers a write and a read committing together
    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) begin
            cnt  <= '0;
            hold <= '0;
        end else begin
            unique case ({wr_commit, rd_commit})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (load) hold <= rdata;
        end
    end

    assign in_ready  = wr_rdy & mr_n;
    assign out_ready = rd_valid;
    assign dout      = oe_n ? '0 : hold;
    assign half_full = mr_n & (cnt >= CW'(HALF_LVL));
    assign almost_fe = mr_n & ((cnt >= CW'(AF_LVL)) | (cnt <= CW'(AE_LVL)));
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
    parameter int DW    = 5,
    parameter int CW    = 7,
    parameter int DEPTH = 64
) (
    input logic          clk,
    input logic          mr_n,
    input logic          oe_n,
    input logic          in_ready,
    input logic          out_ready,
    input logic          half_full,
    input logic          almost_fe,
    input logic [DW-1:0] dout,
    input logic [CW-1:0] cnt
);
    // R3
    full_blocks_in_chk: assert property (@(posedge clk) disable iff (!mr_n)
        (cnt == CW'(DEPTH)) |-> !in_ready);

    // R6
    empty_blocks_out_chk: assert property (@(posedge clk) disable iff (!mr_n)
        (cnt == '0) |-> !out_ready);

    // R12
    cnt_step_up_chk: assert property (@(posedge clk) disable iff (!mr_n)
        (cnt > $past(cnt)) |-> (cnt == $past(cnt) + CW'(1)));

    // R12
    cnt_step_dn_chk: assert property (@(posedge clk) disable iff (!mr_n)
        (cnt < $past(cnt)) |-> (cnt == $past(cnt) - CW'(1)));

    // R6
    dout_hold_chk: assert property (@(posedge clk) disable iff (!mr_n)
        (!out_ready && $past(!out_ready) && $stable(oe_n)) |-> $stable(dout));

    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (!mr_n)
        oe_n |-> (dout == '0));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !mr_n |-> (!in_ready && !out_ready && !half_full && !almost_fe && dout == '0));
endmodule

bind strobe_fifo sfifo_chk #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .mr_n     (mr_n),
    .oe_n     (oe_n),
    .in_ready (in_ready),
    .out_ready(out_ready),
    .half_full(half_full),
    .almost_fe(almost_fe),
    .dout     (dout),
    .cnt      (cnt)
);

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;
    localparam int DW    = 5;
    localparam int DEPTH = 64;
    localparam int NVEC  = 10;

    logic          clk = 1'b0;
    logic          mr_n = 1'b0;
    logic          shift_in = 1'b0;
    logic          shift_out = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic          in_ready, out_ready, half_full, almost_fe;
    logic [DW-1:0] dout;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    logic [DW-1:0] mq[$];
    logic [DW-1:0] last = '0;

    // vector: op (0 write, 1 read, 2 both), data, expected occupancy afterwards
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd0, 5'h11, 7'd1}, {2'd0, 5'h0A, 7'd2}, {2'd1, 5'h00, 7'd1},
        {2'd0, 5'h1F, 7'd2}, {2'd2, 5'h03, 7'd2}, {2'd1, 5'h00, 7'd1},
        {2'd1, 5'h00, 7'd0}, {2'd1, 5'h00, 7'd0}, {2'd0, 5'h15, 7'd1},
        {2'd1, 5'h00, 7'd0}
    };

    always #4 clk = ~clk;

    strobe_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .mr_n(mr_n), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
        .oe_n(oe_n), .dout(dout), .half_full(half_full), .almost_fe(almost_fe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string where);
        int n = mq.size();
        chk({"R3 in_ready ", where}, 32'(in_ready), 32'(n < DEPTH));
        chk({"R5 out_ready ", where}, 32'(out_ready), 32'(n > 0));
        chk({"R1 dout ", where}, 32'(dout), 32'((n > 0) ? mq[0] : last));
        chk({"R9 half_full ", where}, 32'(half_full), 32'(n >= 32));
        chk({"R10 almost_fe ", where}, 32'(almost_fe), 32'((n >= 56) || (n <= 8)));
    endtask

    task automatic push(input logic [DW-1:0] d);
        bit take = (mq.size() < DEPTH);
        @(negedge clk); din = d; shift_in = 1'b1;
        repeat (5) @(negedge clk);
        if (take) chk("R2 in_ready low during write strobe", 32'(in_ready), 32'd0);
        shift_in = 1'b0;
        repeat (5) @(negedge clk);
        if (take) mq.push_back(d);
    endtask

    task automatic pop();
        bit take = (mq.size() > 0);
        @(negedge clk); shift_out = 1'b1;
        repeat (5) @(negedge clk);
        if (take) chk("R5 out_ready low during read strobe", 32'(out_ready), 32'd0);
        shift_out = 1'b0;
        repeat (5) @(negedge clk);
        if (take) last = mq.pop_front();
    endtask

    task automatic both(input logic [DW-1:0] d);
        bit tw = (mq.size() < DEPTH);
        bit tr = (mq.size() > 0);
        @(negedge clk); din = d; shift_in = 1'b1; shift_out = 1'b1;
        repeat (5) @(negedge clk);
        shift_in = 1'b0; shift_out = 1'b0;
        repeat (5) @(negedge clk);
        if (tr) last = mq.pop_front();
        if (tw) mq.push_back(d);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        // R8: outputs quiet while reset is held
        repeat (3) @(negedge clk);
        chk("R8 in_ready in reset", 32'(in_ready), 32'd0);
        chk("R8 out_ready in reset", 32'(out_ready), 32'd0);
        chk("R8 dout in reset", 32'(dout), 32'd0);
        chk("R8 half_full in reset", 32'(half_full), 32'd0);
        chk("R8 almost_fe in reset", 32'(almost_fe), 32'd0);
        mr_n = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R8 after release");

        // R7: one cycle of fall-through after commit into empty buffer
        @(negedge clk); din = 5'h09; shift_in = 1'b1;
        repeat (5) @(negedge clk);
        shift_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 out_ready still low on commit cycle", 32'(out_ready), 32'd0);
        @(negedge clk);
        chk("R7 out_ready high one cycle later", 32'(out_ready), 32'd1);
        chk("R7 dout shows fall-through word", 32'(dout), 32'h09);
        mq.push_back(5'h09);
        repeat (2) @(negedge clk);
        pop();
        check_state("R7 drained");

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            unique case (VEC[i][13:12])
                2'd0:    push(VEC[i][11:7]);
                2'd1:    pop();
                default: both(VEC[i][11:7]);
            endcase
            chk("R12 vector occupancy model", 32'(mq.size()), 32'(VEC[i][6:0]));
            check_state("vector");
        end

        // R6: read strobe on empty buffer is ignored, last word stays
        pop();
        chk("R6 dout keeps last word", 32'(dout), 32'(last));
        check_state("R6 empty read");

        // fill through every threshold to full
        for (int i = mq.size(); i < DEPTH; i++) begin
            push(5'((i * 7 + 3) % 32));
            check_state("fill");
        end

        // R3: write strobe while full is ignored
        push(5'h1E);
        check_state("R3 ignored write");

        // R4: write strobe held high across a read that frees a slot
        @(negedge clk); din = 5'h0D; shift_in = 1'b1;
        repeat (6) @(negedge clk);
        pop();
        chk("R4 pending word taken, in_ready low", 32'(in_ready), 32'd0);
        shift_in = 1'b0;
        repeat (5) @(negedge clk);
        mq.push_back(5'h0D);
        check_state("R4 full again");

        // R1: drain in order through every threshold
        while (mq.size() > 0) begin
            pop();
            check_state("R1 drain");
        end

        // R11: output enable gating
        oe_n = 1'b1;
        @(negedge clk);
        chk("R11 dout zero when disabled", 32'(dout), 32'd0);
        oe_n = 1'b0;
        @(negedge clk);
        chk("R11 dout restored when enabled", 32'(dout), 32'(last));

        // R12: simultaneous commits at 32 and 31 words
        for (int i = 0; i < 32; i++) push(5'(i));
        both(5'h19);
        chk("R12 half_full kept at 32", 32'(half_full), 32'd1);
        check_state("R12 at 32");
        pop();
        both(5'h06);
        chk("R12 half_full clear at 31", 32'(half_full), 32'd0);
        check_state("R12 at 31");

        // R8: reset in the middle of operation
        @(negedge clk); mr_n = 1'b0;
        @(negedge clk);
        chk("R8 out_ready cleared", 32'(out_ready), 32'd0);
        chk("R8 dout cleared", 32'(dout), 32'd0);
        chk("R8 half_full cleared", 32'(half_full), 32'd0);
        mr_n = 1'b1;
        repeat (3) @(negedge clk);
        mq.delete();
        last = '0;
        check_state("R8 after mid reset");

        finish_run();
    end
endmodule